// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers and status words of a 32-bit processor that runs in several operating modes. Software names a register with a 4-bit architectural index. The physical storage behind that index depends on the 5-bit mode field. Registers 0 to 7 and the program counter are common to all modes. The fast-interrupt mode swaps in private copies of registers 8 to 14. The other four exception modes each swap in only a private stack pointer (13) and link register (14).

The block has two combinational read ports and one write port that updates on the rising clock edge. A saved-status port reaches the saved status copy of whichever privileged mode is current. A current-status port holds the single live status word. A user-bank override input makes the general ports address the user-mode registers from any mode, so that an exception handler can save or restore them. Altogether the block stores 37 words: 31 general, one current status and five saved status.

Top module: `bankrf_top`

## Requirements
- R1: A synchronous reset, held high over a rising edge, clears all 37 stored words to zero. After it, every read port, the saved-status output and the current-status output all read zero.
- R2: Indices 0 to 7 address the same storage in every mode and with either value of the override.
- R3: Index 15, the program counter, is one word shared by every mode.
- R4: In fast-interrupt mode (10001), indices 8 to 14 address seven private words. Writing them leaves the user copies untouched, and writing the user copies leaves them untouched.
- R5: The interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have their own words at indices 13 and 14. At indices 8 to 12 they use the user copies.
- R6: User (10000) and system (11111) modes use the same words. Any mode value outside the seven listed codes is mapped like user mode.
- R7: Each of the five modes fast-interrupt, interrupt, supervisor, abort and undefined has its own saved-status word. It is reached through the saved-status port while that mode is current, and the override input has no effect on it.
- R8: In user mode, system mode or an unlisted mode, the saved-status output reads zero and a saved-status write changes no stored word.
- R9: While the override input is 1, all three general ports map as in user mode, whatever the mode field holds.
- R10: A write takes effect at the rising edge. A read of the same word in the same cycle returns the value from before the write.
- R11: The current-status word takes its write data at the edge when its write enable is 1, and holds its value otherwise.
- R12: While the general write enable is 0, no general word changes, whatever the write index and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current operating mode code |
| usr_bank | input | 1 | Forces user-mode mapping on the general ports |
| ra_idx | input | 4 | Read port A architectural index |
| ra_data | output | DATA_W | Read port A data |
| rb_idx | input | 4 | Read port B architectural index |
| rb_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | DATA_W | General write data |
| sv_we | input | 1 | Saved-status write enable |
| sv_wdata | input | DATA_W | Saved-status write data |
| sv_rdata | output | DATA_W | Saved status of the current mode |
| st_we | input | 1 | Current-status write enable |
| st_wdata | input | DATA_W | Current-status write data |
| st_rdata | output | DATA_W | Current-status word |

## Verification
The bench builds the block with the default DATA_W of 32 and drives random full-width data. A fault in any bit lane of any of the 37 words therefore shows up on the outputs. Random mode codes include an unlisted value and occasional use of the override. This brings every pairing of bank and index within reach, including a read and a write of the same word in one cycle. Directed sequences cover bank isolation, system and user sharing, the saved-status words, and a reset in the middle of the run.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int IDX_W     = 4;
    localparam int NUM_GPR   = 31;
    localparam int PHYS_W    = $clog2(NUM_GPR);
    localparam int NUM_SAVED = 5;
    localparam int SLOT_W    = $clog2(NUM_SAVED);
    localparam int MODE_W    = 5;

    // Base physical slots of the banked groups
    localparam logic [PHYS_W-1:0] FIQ_BASE = 5'd16;
    localparam logic [PHYS_W-1:0] IRQ_BASE = 5'd23;
    localparam logic [PHYS_W-1:0] SVC_BASE = 5'd25;
    localparam logic [PHYS_W-1:0] ABT_BASE = 5'd27;
    localparam logic [PHYS_W-1:0] UND_BASE = 5'd29;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    function automatic bank_e decode_mode(input logic [MODE_W-1:0] m);
        bank_e b;
        case (m)
            MODE_FIQ: b = BANK_FIQ;
            MODE_IRQ: b = BANK_IRQ;
            MODE_SVC: b = BANK_SVC;
            MODE_ABT: b = BANK_ABT;
            MODE_UND: b = BANK_UND;
            default:  b = BANK_USR;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bankrf_mode_dec.sv
module bankrf_mode_dec
    import bankrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              usr_bank,
    output bank_e             map_bank,
    output logic              saved_valid,
    output logic [SLOT_W-1:0] saved_slot
);

    bank_e cur_bank;

    always_comb begin
        cur_bank = decode_mode(mode);
        map_bank = usr_bank ? BANK_USR : cur_bank;
    end

    // Saved-status slot follows the true mode, never the override
    always_comb begin
        saved_valid = 1'b1;
        saved_slot  = '0;
        case (cur_bank)
            BANK_FIQ: saved_slot = 3'd0;
            BANK_IRQ: saved_slot = 3'd1;
            BANK_SVC: saved_slot = 3'd2;
            BANK_ABT: saved_slot = 3'd3;
            BANK_UND: saved_slot = 3'd4;
            default:  saved_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/bankrf_map.sv
module bankrf_map
    import bankrf_pkg::*;
(
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [PHYS_W-1:0] phys
);

    logic              fiq_hit;
    logic              sp_lr;
    logic [PHYS_W-1:0] pair_base;

    always_comb begin
        fiq_hit = (bank == BANK_FIQ) && (idx >= 4'd8) && (idx <= 4'd14);
        sp_lr   = (idx == 4'd13) || (idx == 4'd14);
        case (bank)
            BANK_IRQ: pair_base = IRQ_BASE;
            BANK_SVC: pair_base = SVC_BASE;
            BANK_ABT: pair_base = ABT_BASE;
            BANK_UND: pair_base = UND_BASE;
            default:  pair_base = '0;
        endcase

        phys = {1'b0, idx};
        if (fiq_hit) begin
            phys = FIQ_BASE + {2'b00, idx[2:0]};
        end else if (sp_lr && (pair_base != '0)) begin
            phys = pair_base + {4'b0000, ~idx[0]};
        end
    end

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              usr_bank,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sv_we,
    input  logic [DATA_W-1:0] sv_wdata,
    output logic [DATA_W-1:0] sv_rdata,
    input  logic              st_we,
    input  logic [DATA_W-1:0] st_wdata,
    output logic [DATA_W-1:0] st_rdata
);

    localparam int NUM_PORTS = 3;
    localparam int WR_PORT   = NUM_PORTS - 1;

    typedef struct packed {
        logic [NUM_GPR-1:0][DATA_W-1:0]   gpr;
        logic [NUM_SAVED-1:0][DATA_W-1:0] saved;
        logic [DATA_W-1:0]                status;
    } state_t;

    state_t s_d, s_q;

    bank_e             map_bank;
    logic              saved_valid;
    logic [SLOT_W-1:0] saved_slot;

    bankrf_mode_dec u_dec (
        .mode        (mode),
        .usr_bank    (usr_bank),
        .map_bank    (map_bank),
        .saved_valid (saved_valid),
        .saved_slot  (saved_slot)
    );

    logic [IDX_W-1:0]  port_idx  [NUM_PORTS];
    logic [PHYS_W-1:0] port_phys [NUM_PORTS];

    assign port_idx[0]       = ra_idx;
    assign port_idx[1]       = rb_idx;
    assign port_idx[WR_PORT] = wr_idx;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
        bankrf_map u_map (
            .bank (map_bank),
            .idx  (port_idx[p]),
            .phys (port_phys[p])
        );
    end

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d = '0;
        end else begin
            if (wr_en) begin
                s_d.gpr[port_phys[WR_PORT]] = wr_data;
            end
            if (sv_we && saved_valid) begin
                s_d.saved[saved_slot] = sv_wdata;
            end
            if (st_we) begin
                s_d.status = st_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign ra_data  = s_q.gpr[port_phys[0]];
    assign rb_data  = s_q.gpr[port_phys[1]];
    assign sv_rdata = saved_valid ? s_q.saved[saved_slot] : '0;
    assign st_rdata = s_q.status;

endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode,
    input logic              usr_bank,
    input logic [IDX_W-1:0]  ra_idx,
    input logic [DATA_W-1:0] ra_data,
    input logic [IDX_W-1:0]  rb_idx,
    input logic [DATA_W-1:0] rb_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              sv_we,
    input logic [DATA_W-1:0] sv_wdata,
    input logic [DATA_W-1:0] sv_rdata,
    input logic              st_we,
    input logic [DATA_W-1:0] st_wdata,
    input logic [DATA_W-1:0] st_rdata
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ra_data == '0) && (rb_data == '0) && (sv_rdata == '0) && (st_rdata == '0));

    // R2
    low_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && ($past(wr_idx) < 4'd8) && (ra_idx == $past(wr_idx)))
        |-> (ra_data == $past(wr_data)));

    // R3
    pc_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && ($past(wr_idx) == 4'd15) && (rb_idx == 4'd15))
        |-> (rb_data == $past(wr_data)));

    // R10
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && (ra_idx == $past(wr_idx)) && (mode == $past(mode))
         && (usr_bank == $past(usr_bank)))
        |-> (ra_data == $past(wr_data)));

    // R8
    saved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_USR) || (mode == MODE_SYS)) |-> (sv_rdata == '0));

    // R7
    saved_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sv_we) && ($past(mode) == MODE_SVC) && (mode == MODE_SVC))
        |-> (sv_rdata == $past(sv_wdata)));

    // R11
    status_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st_we)) |-> (st_rdata == $past(st_wdata)));

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(st_we)) |-> $stable(st_rdata));

endmodule

bind bankrf_top bankrf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .usr_bank (usr_bank),
    .ra_idx   (ra_idx),
    .ra_data  (ra_data),
    .rb_idx   (rb_idx),
    .rb_data  (rb_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sv_we    (sv_we),
    .sv_wdata (sv_wdata),
    .sv_rdata (sv_rdata),
    .st_we    (st_we),
    .st_wdata (st_wdata),
    .st_rdata (st_rdata)
);

// File: tb/bankrf_top_bench.sv
module bankrf_top_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic [4:0]   mode;
    logic         usr_bank;
    logic [3:0]   ra_idx, rb_idx, wr_idx;
    logic [W-1:0] ra_data, rb_data, wr_data;
    logic         wr_en, sv_we, st_we;
    logic [W-1:0] sv_wdata, sv_rdata, st_wdata, st_rdata;

    always #4 clk = ~clk;

    bankrf_top #(.DATA_W(W)) u_bankrf_top (
        .clk(clk), .rst(rst), .mode(mode), .usr_bank(usr_bank),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sv_we(sv_we), .sv_wdata(sv_wdata), .sv_rdata(sv_rdata),
        .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata)
    );

    // Reference storage, organised per bank
    logic [W-1:0] usr_r [16];
    logic [W-1:0] fiq_r [7];
    logic [W-1:0] sp_r  [4];
    logic [W-1:0] lr_r  [4];
    logic [W-1:0] sv_m  [5];
    logic [W-1:0] st_m;

    int    checks = 0;
    int    errors = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    // 0 user/system/other, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [W-1:0] m_read(input int idx, input logic [4:0] m, input bit ub);
        int b;
        b = ub ? 0 : bank_of(m);
        if (idx < 8 || idx == 15) return usr_r[idx];
        if (b == 1) return fiq_r[idx-8];
        if (b >= 2 && idx == 13) return sp_r[b-2];
        if (b >= 2 && idx == 14) return lr_r[b-2];
        return usr_r[idx];
    endfunction

    function automatic logic [W-1:0] m_saved(input logic [4:0] m);
        int b;
        b = bank_of(m);
        return (b == 0) ? '0 : sv_m[b-1];
    endfunction

    task automatic m_clear();
        for (int i = 0; i < 16; i++) usr_r[i] = '0;
        for (int i = 0; i < 7; i++) fiq_r[i] = '0;
        for (int i = 0; i < 4; i++) begin sp_r[i] = '0; lr_r[i] = '0; end
        for (int i = 0; i < 5; i++) sv_m[i] = '0;
        st_m = '0;
    endtask

    task automatic m_update();
        int b;
        int sb;
        if (rst) begin
            m_clear();
            return;
        end
        b  = usr_bank ? 0 : bank_of(mode);
        sb = bank_of(mode);
        if (wr_en) begin
            if (wr_idx < 8 || wr_idx == 15) usr_r[wr_idx] = wr_data;
            else if (b == 1) fiq_r[wr_idx-8] = wr_data;
            else if (b >= 2 && wr_idx == 13) sp_r[b-2] = wr_data;
            else if (b >= 2 && wr_idx == 14) lr_r[b-2] = wr_data;
            else usr_r[wr_idx] = wr_data;
        end
        if (sv_we && sb != 0) sv_m[sb-1] = sv_wdata;
        if (st_we) st_m = st_wdata;
    endtask

    task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Inputs are set at the falling edge; compare, then advance one clock
    task automatic tick();
        #1;
        chk({tag, " port A"}, ra_data, m_read(ra_idx, mode, usr_bank));
        chk({tag, " port B"}, rb_data, m_read(rb_idx, mode, usr_bank));
        if (!rst) begin
            chk({tag, " saved"}, sv_rdata, m_saved(mode));
            chk({tag, " status"}, st_rdata, st_m);
        end
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; sv_we = 0; st_we = 0; usr_bank = 0;
    endtask

    task automatic wr(input logic [4:0] m, input bit ub, input int idx, input logic [W-1:0] d);
        idle();
        mode = m; usr_bank = ub; wr_en = 1; wr_idx = 4'(idx); wr_data = d;
        tick();
        idle();
    endtask

    task automatic rd(input logic [4:0] m, input bit ub, input int a, input int b);
        idle();
        mode = m; usr_bank = ub; ra_idx = 4'(a); rb_idx = 4'(b);
        tick();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111, BAD = 5'b01010;

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [4:0] modes [8];
        modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, BAD};
        void'($urandom(32'd20240611));
        m_clear();
        rst = 1; idle(); mode = USR; ra_idx = 0; rb_idx = 0; wr_idx = 0;
        wr_data = '0; sv_wdata = '0; st_wdata = '0;
        @(negedge clk);
        tick(); tick();
        rst = 0;

        // R1: every index reads zero out of reset
        tag = "R1";
        for (int i = 0; i < 16; i++) rd(FIQ, 0, i, i);
        for (int i = 13; i < 15; i++) rd(UND, 0, i, i);

        // R4: fiq private bank against user copies
        tag = "R4";
        for (int i = 8; i < 15; i++) wr(USR, 0, i, 32'h1000_0000 + i);
        for (int i = 8; i < 15; i++) wr(FIQ, 0, i, 32'hF000_0000 + i);
        for (int i = 8; i < 15; i++) rd(FIQ, 0, i, i);
        rd(USR, 0, 8, 14);
        chk("R4 user r8 kept", ra_data, 32'h1000_0008);

        // R5: per-mode stack pointer and link register
        tag = "R5";
        wr(IRQ, 0, 13, 32'hA13); wr(SVC, 0, 13, 32'hB13);
        wr(ABT, 0, 14, 32'hC14); wr(UND, 0, 14, 32'hD14);
        wr(SVC, 0, 10, 32'h5A5A_0010);
        rd(IRQ, 0, 13, 14); rd(SVC, 0, 13, 10); rd(ABT, 0, 14, 13); rd(UND, 0, 14, 12);
        rd(USR, 0, 10, 13);
        chk("R5 shared r10 seen by user", ra_data, 32'h5A5A_0010);

        // R6: system and unlisted codes share user registers
        tag = "R6";
        wr(SYS, 0, 13, 32'h5151_0013);
        rd(USR, 0, 13, 14);
        chk("R6 system r13 seen by user", ra_data, 32'h5151_0013);
        wr(BAD, 0, 14, 32'hBAD0_0014);
        rd(SYS, 0, 14, 9);

        // R2 and R3: low registers and program counter everywhere
        tag = "R2";
        wr(UND, 0, 3, 32'h0303_0303);
        for (int k = 0; k < 8; k++) rd(modes[k], 0, 3, 7);
        tag = "R3";
        wr(FIQ, 0, 15, 32'h1515_1515);
        for (int k = 0; k < 8; k++) rd(modes[k], 0, 15, 0);
        chk("R3 pc shared", ra_data, 32'h1515_1515);

        // R9: override reaches user copies from privileged modes
        tag = "R9";
        wr(FIQ, 1, 9, 32'h9999_0009);
        wr(IRQ, 1, 13, 32'h9999_0013);
        rd(USR, 0, 9, 13);
        chk("R9 user r9 via override", ra_data, 32'h9999_0009);
        chk("R9 user r13 via override", rb_data, 32'h9999_0013);
        rd(FIQ, 0, 9, 9);

        // R7 and R8: saved status words
        tag = "R7";
        for (int k = 1; k < 6; k++) begin
            idle(); mode = modes[k]; usr_bank = (k == 3); sv_we = 1; sv_wdata = 32'h5000_0000 + k;
            tick();
        end
        for (int k = 1; k < 6; k++) rd(modes[k], 0, 0, 0);
        tag = "R8";
        for (int k = 0; k < 8; k++) begin
            if (k == 0 || k >= 6) begin
                idle(); mode = modes[k]; sv_we = 1; sv_wdata = 32'hDEAD_BEEF;
                tick();
            end
        end
        for (int k = 0; k < 8; k++) rd(modes[k], 0, 0, 0);

        // R10: same-cycle write and read returns the old value
        tag = "R10";
        idle(); mode = SVC; wr_en = 1; wr_idx = 13; wr_data = 32'hCAFE_0001;
        ra_idx = 13; rb_idx = 13;
        tick();
        idle(); tick();

        // R12: write enable low changes nothing
        tag = "R12";
        idle(); mode = FIQ; wr_idx = 8; wr_data = 32'hFFFF_FFFF; ra_idx = 8;
        tick(); tick();

        // R11: current status load and hold
        tag = "R11";
        idle(); st_we = 1; st_wdata = 32'h8000_001F; tick();
        idle(); st_wdata = 32'h1234_5678; tick(); tick();

        // Random mix, all requirements via the reference
        tag = "R10 random";
        for (int n = 0; n < 3000; n++) begin
            idle();
            mode     = modes[$urandom_range(7)];
            usr_bank = ($urandom_range(7) == 0);
            ra_idx   = 4'($urandom_range(15));
            rb_idx   = 4'($urandom_range(15));
            wr_en    = ($urandom_range(9) < 6);
            wr_idx   = ($urandom_range(3) == 0) ? ra_idx : 4'($urandom_range(15));
            wr_data  = $urandom;
            sv_we    = ($urandom_range(3) == 0);
            sv_wdata = $urandom;
            st_we    = ($urandom_range(3) == 0);
            st_wdata = $urandom;
            tick();
        end

        // R1: reset in the middle of traffic
        tag = "R1";
        idle(); rst = 1; wr_en = 1; wr_idx = 5; wr_data = 32'h7777_7777; tick();
        rst = 0; idle();
        for (int i = 0; i < 16; i++) rd(FIQ, 0, i, i);
        for (int k = 0; k < 8; k++) rd(modes[k], 0, 13, 14);

        done = 1'b1;
        report();
    end

endmodule